// File: doc/BRIEF.md
# PLL Bring-Up and Lock Retry Supervisor

This block sequences the power-up of a phase-locked loop and confirms that it locks. On a start request it first turns on the analog bias (bandgap) once and waits for it, then enables the PLL with its reset asserted. After a hold time it releases the reset and waits a settle time. It then samples a synchronized copy of the lock status.

If the PLL has locked, the sequence completes and the failure count clears. If it has not, the failure count increments and the reset pulse, settle and check steps run again. When the count reaches a configured limit, the block gives up and raises a sticky system-reset request. All waits are counted in microsecond tick pulses, so the real-time durations come from parameters. The divider configuration word is captured when a start request is accepted and is presented to the PLL unchanged.

Top module: `pll_lock_supervisor`

## Requirements
- R1: After rst_ni is released, every output is low: bias_en_o, pll_en_o, pll_rst_o, done_o, sys_rst_req_o, attempt_o = 0 and pll_cfg_o = 0.
- R2: The first accepted start raises bias_en_o, which then stays high until rst_ni. pll_en_o stays low for exactly BIAS_US tick pulses after that. Later starts skip this wait.
- R3: Each attempt drives pll_en_o and pll_rst_o high together for exactly HOLD_US tick pulses. pll_rst_o is never high while pll_en_o is low.
- R4: After pll_rst_o falls, pll_en_o stays high for exactly SETTLE_US tick pulses before the lock status is sampled.
- R5: lock_i passes through a two-flop synchronizer. If it reads 1 at the sample point, done_o rises and attempt_o returns to 0.
- R6: If lock reads 0 at the sample point, attempt_o increments by one and a new reset pulse begins. At the rising edge of the j-th reset pulse, attempt_o equals j-1.
- R7: When attempt_o reaches RETRY_LIMIT, sys_rst_req_o rises and pll_en_o falls, with exactly RETRY_LIMIT reset pulses issued. sys_rst_req_o stays high, and start_i is ignored, until rst_ni.
- R8: done_o stays high until the next start_i. A start while done begins a new attempt without the bias wait.
- R9: A start_i pulse that arrives while a sequence is in progress has no effect on the reset pulse count or on pll_cfg_o.
- R10: cfg_i is captured on an accepted start and driven on pll_cfg_o for the rest of the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Single-cycle request to begin bring-up |
| tick_i | input | 1 | One-cycle pulse per microsecond |
| lock_i | input | 1 | Asynchronous PLL lock status |
| cfg_i | input | CFG_W | Divider configuration word |
| bias_en_o | output | 1 | Bandgap/bias enable |
| pll_en_o | output | 1 | PLL enable |
| pll_rst_o | output | 1 | PLL reset |
| pll_cfg_o | output | CFG_W | Captured divider configuration |
| done_o | output | 1 | PLL locked, sequence complete |
| attempt_o | output | $clog2(RETRY_LIMIT+1) | Consecutive failed lock checks |
| sys_rst_req_o | output | 1 | Escalation request after too many failures |

## Verification
The hardest states to reach are those that depend on how many attempts fail: the exact number of failures before a lock, and the escalation when the limit is reached. The bench controls lock_i per attempt. It counts rising edges of pll_rst_o and drives lock high only once that count passes a chosen value k. Sweeping k from 0 up to the retry limit covers every possible failure count, including the escalation case. In each case, hold, settle and bias durations are measured in observed tick pulses.

// File: rtl/pll_sup_pkg.sv
package pll_sup_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_BIAS, ST_HOLD, ST_SETTLE, ST_CHECK, ST_DONE, ST_FAIL
  } sup_state_e;
endpackage

// File: rtl/lock_sync.sv
module lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end
  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/us_wait_timer.sv
module us_wait_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [CW-1:0] last_i,   // terminal count minus one
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;
  assign expire_o = run_i && tick_i && (cnt_q == last_i);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || expire_o) cnt_q <= '0;
    else if (tick_i)            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pll_lock_supervisor.sv
module pll_lock_supervisor
  import pll_sup_pkg::*;
#(
  parameter int CFG_W       = 24,
  parameter int BIAS_US     = 100,
  parameter int HOLD_US     = 1,
  parameter int SETTLE_US   = 20,
  parameter int RETRY_LIMIT = 8,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(RETRY_LIMIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic             lock_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             bias_en_o,
  output logic             pll_en_o,
  output logic             pll_rst_o,
  output logic [CFG_W-1:0] pll_cfg_o,
  output logic             done_o,
  output logic [AW-1:0]    attempt_o,
  output logic             sys_rst_req_o
);
  localparam int MAX_A  = (BIAS_US > HOLD_US) ? BIAS_US : HOLD_US;
  localparam int MAX_US = (MAX_A > SETTLE_US) ? MAX_A : SETTLE_US;
  localparam int TW     = (MAX_US > 1) ? $clog2(MAX_US) : 1;

  sup_state_e      state_q, state_d;
  logic            bias_on_q;
  logic [AW-1:0]   fail_q;
  logic [CFG_W-1:0] cfg_q;
  logic            lock_s, run, expire, accept;
  logic [TW-1:0]   last;

  lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(lock_i), .q_o(lock_s)
  );

  always_comb begin
    unique case (state_q)
      ST_BIAS: last = TW'(BIAS_US - 1);
      ST_HOLD: last = TW'(HOLD_US - 1);
      default: last = TW'(SETTLE_US - 1);
    endcase
  end

  assign run = (state_q == ST_BIAS) || (state_q == ST_HOLD) || (state_q == ST_SETTLE);

  us_wait_timer #(.CW(TW)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .tick_i(tick_i),
    .last_i(last), .expire_o(expire)
  );

  assign accept = start_i && ((state_q == ST_IDLE) || (state_q == ST_DONE));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = bias_on_q ? ST_HOLD : ST_BIAS;
      ST_BIAS:   if (expire) state_d = ST_HOLD;
      ST_HOLD:   if (expire) state_d = ST_SETTLE;
      ST_SETTLE: if (expire) state_d = ST_CHECK;
      ST_CHECK:
        if (lock_s)                            state_d = ST_DONE;
        else if (fail_q == AW'(RETRY_LIMIT - 1)) state_d = ST_FAIL;
        else                                   state_d = ST_HOLD;
      ST_DONE:   if (start_i) state_d = ST_HOLD;
      ST_FAIL:   state_d = ST_FAIL;   // left only through rst_ni
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bias_on_q <= 1'b0;
      fail_q    <= '0;
      cfg_q     <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        cfg_q     <= cfg_i;
        bias_on_q <= 1'b1;
      end
      if (state_q == ST_CHECK) fail_q <= lock_s ? '0 : fail_q + 1'b1;
    end
  end

  assign bias_en_o     = bias_on_q;
  assign pll_en_o      = (state_q == ST_HOLD) || (state_q == ST_SETTLE) ||
                         (state_q == ST_CHECK) || (state_q == ST_DONE);
  assign pll_rst_o     = (state_q == ST_HOLD);
  assign pll_cfg_o     = cfg_q;
  assign done_o        = (state_q == ST_DONE);
  assign attempt_o     = fail_q;
  assign sys_rst_req_o = (state_q == ST_FAIL);
endmodule

// File: rtl/pll_lock_supervisor_chk.sv
module pll_lock_supervisor_chk #(
  parameter int CFG_W       = 24,
  parameter int RETRY_LIMIT = 8,
  localparam int AW = $clog2(RETRY_LIMIT + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             bias_en_o,
  input logic             pll_en_o,
  input logic             pll_rst_o,
  input logic [CFG_W-1:0] pll_cfg_o,
  input logic             done_o,
  input logic [AW-1:0]    attempt_o,
  input logic             sys_rst_req_o
);
  p_rst_needs_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_rst_o |-> pll_en_o);
  p_bias_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bias_en_o |=> bias_en_o);
  p_attempt_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (attempt_o != $past(attempt_o)) |-> (attempt_o == $past(attempt_o) + 1'b1 || attempt_o == '0));
  p_attempt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attempt_o <= AW'(RETRY_LIMIT));
  p_sysrst_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o |=> (sys_rst_req_o && !pll_en_o));
  p_done_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
  p_done_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && sys_rst_req_o));
  p_cfg_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pll_en_o && !done_o) |=> $stable(pll_cfg_o));
endmodule

bind pll_lock_supervisor pll_lock_supervisor_chk #(
  .CFG_W(CFG_W), .RETRY_LIMIT(RETRY_LIMIT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .bias_en_o(bias_en_o),
  .pll_en_o(pll_en_o), .pll_rst_o(pll_rst_o), .pll_cfg_o(pll_cfg_o),
  .done_o(done_o), .attempt_o(attempt_o), .sys_rst_req_o(sys_rst_req_o)
);

// File: tb/pll_lock_supervisor_bench.sv
module pll_lock_supervisor_bench;
  localparam int CFG_W = 12;
  localparam int BIAS  = 3;
  localparam int HOLD  = 2;
  localparam int SETT  = 4;
  localparam int RL    = 3;
  localparam int AW    = $clog2(RL + 1);

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0, tick_i = 1'b0, lock_i = 1'b0;
  logic [CFG_W-1:0] cfg_i = '0;
  logic bias_en_o, pll_en_o, pll_rst_o, done_o, sys_rst_req_o;
  logic [CFG_W-1:0] pll_cfg_o;
  logic [AW-1:0] attempt_o;

  int checks = 0, fails = 0, cyc = 0;
  int k_q = 0, pulses = 0, hold_t = 0, sett_t = 0, bias_t = 0, att_err = 0;
  logic prev_rst = 1'b0;

  always #4 clk = ~clk;

  pll_lock_supervisor #(.CFG_W(CFG_W), .BIAS_US(BIAS), .HOLD_US(HOLD),
    .SETTLE_US(SETT), .RETRY_LIMIT(RL)) u_pll_lock_supervisor (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .tick_i(tick_i),
    .lock_i(lock_i), .cfg_i(cfg_i), .bias_en_o(bias_en_o), .pll_en_o(pll_en_o),
    .pll_rst_o(pll_rst_o), .pll_cfg_o(pll_cfg_o), .done_o(done_o),
    .attempt_o(attempt_o), .sys_rst_req_o(sys_rst_req_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // tick every 4 cycles, driven just after the edge
  initial begin
    int tc = 0;
    forever begin
      @(posedge clk); #1;
      tc = (tc + 1) % 4;
      tick_i = (tc == 0);
    end
  end

  // monitor: phase tick counts and per-attempt lock control
  always @(negedge clk) begin
    cyc++;
    if (pll_rst_o && !prev_rst) begin
      pulses++;
      if (int'(attempt_o) != pulses - 1) att_err++;
      lock_i = (pulses > k_q);
    end
    prev_rst = pll_rst_o;
    if (tick_i && pll_rst_o) hold_t++;
    if (tick_i && pll_en_o && !pll_rst_o && !done_o && !sys_rst_req_o) sett_t++;
    if (tick_i && bias_en_o && !pll_en_o && !done_o && !sys_rst_req_o) bias_t++;
  end

  initial begin
    wait (cyc > 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic pulse_start(input logic [CFG_W-1:0] c);
    @(posedge clk); #1; start_i = 1'b1; cfg_i = c;
    @(posedge clk); #1; start_i = 1'b0;
  endtask

  task automatic run(input int k, input logic [CFG_W-1:0] c, input int exp_bias, input bit busy_start);
    bit exp_fail;
    int exp_p;
    exp_fail = (k >= RL);
    exp_p    = exp_fail ? RL : k + 1;
    k_q = k; pulses = 0; hold_t = 0; sett_t = 0; bias_t = 0; att_err = 0;
    lock_i = 1'b0;
    pulse_start(c);
    if (busy_start) begin
      wait (pulses >= 1);
      repeat (3) @(posedge clk);
      pulse_start(~c);   // R9: must be ignored
    end
    for (int i = 0; i < 5000 && !(done_o || sys_rst_req_o); i++) @(negedge clk);
    @(negedge clk);
    chk(done_o == !exp_fail, exp_fail ? "R7 done" : "R5 done", int'(done_o), int'(!exp_fail));
    chk(sys_rst_req_o == exp_fail, "R7 sysreq", int'(sys_rst_req_o), int'(exp_fail));
    chk(int'(attempt_o) == (exp_fail ? RL : 0), exp_fail ? "R7 attempt" : "R5 attempt", int'(attempt_o), exp_fail ? RL : 0);
    chk(pulses == exp_p, busy_start ? "R9 pulses" : "R6 pulses", pulses, exp_p);
    chk(att_err == 0, "R6 attempt at pulse", att_err, 0);
    chk(hold_t == exp_p * HOLD, "R3 hold ticks", hold_t, exp_p * HOLD);
    chk(sett_t == exp_p * SETT, "R4 settle ticks", sett_t, exp_p * SETT);
    chk(bias_t == exp_bias, "R2 bias ticks", bias_t, exp_bias);
    chk(pll_cfg_o == c, busy_start ? "R9 cfg" : "R10 cfg", int'(pll_cfg_o), int'(c));
    chk(bias_en_o == 1'b1, "R2 bias held", int'(bias_en_o), 1);
    chk(pll_en_o == !exp_fail, "R7 pll_en", int'(pll_en_o), int'(!exp_fail));
  endtask

  task automatic check_reset_state();
    chk({bias_en_o, pll_en_o, pll_rst_o, done_o, sys_rst_req_o} == 5'b0, "R1 flags",
        int'({bias_en_o, pll_en_o, pll_rst_o, done_o, sys_rst_req_o}), 0);
    chk(attempt_o == '0 && pll_cfg_o == '0, "R1 attempt/cfg", int'(attempt_o), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk); #1 rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check_reset_state();

    run(0, 12'hA5C, BIAS, 1'b0);
    repeat (20) @(negedge clk);
    chk(done_o == 1'b1, "R8 done held", int'(done_o), 1);

    run(1, 12'h3C1, 0, 1'b0);
    run(2, 12'h7E2, 0, 1'b1);

    // escalation, then start must be ignored
    run(RL, 12'h155, 0, 1'b0);
    pulses = 0;
    pulse_start(12'h0F0);
    repeat (40) @(negedge clk);
    chk(sys_rst_req_o == 1'b1, "R7 sticky", int'(sys_rst_req_o), 1);
    chk(pulses == 0, "R7 start ignored", pulses, 0);
    chk(pll_cfg_o == 12'h155, "R7 cfg kept", int'(pll_cfg_o), 'h155);

    // external reset clears everything; bias wait runs again
    @(posedge clk); #1 rst_ni = 1'b0;
    repeat (2) @(posedge clk); #1 rst_ni = 1'b1;
    prev_rst = 1'b0;
    repeat (2) @(negedge clk);
    check_reset_state();
    run(0, 12'h9AB, BIAS, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule